// File: doc/BRIEF.md
# Pulse-Triggered Master-Slave Set/Reset Storage

This block models, cycle by cycle on a fast system clock, a storage element built from two set/reset latches in series. A control input acts as the pulse: while it is high, a first (master) stage follows the set and clear requests, and the visible output stays put. When the pulse ends, a second (slave) stage takes the master's value, and the output changes at that moment.

Because the master listens for the whole pulse, a brief set request that has already gone away by the end of the pulse still reaches the output. This is the ones-catching behaviour of this kind of element, and the block reproduces it deliberately. Two active-low direct inputs force the stored value at once, whatever the pulse is doing. A flag reports the disallowed request in which set and clear are both asked for during a pulse.

The pulse, set and clear lines are ordinary synchronous inputs. They are sampled on each rising system clock edge. The end of a pulse is the first edge at which the pulse is sampled low after being sampled high on the edge before.

Top module: `ms_sr_store`

## Requirements
- R1: While `pulse` is sampled high and both direct inputs are high, `q` keeps its value on that edge, whatever `set_req` and `clr_req` do.
- R2: On the first edge where `pulse` is sampled 0 after being sampled 1, `q` takes the master's value. On every other edge with `pulse` low, `set_req` and `clr_req` change neither `q` nor the master.
- R3: If `set_req` is high for part of a pulse and low when the pulse ends, with `clr_req` low throughout, `q` becomes 1 at the end of the pulse.
- R4: Within one pulse, the last of the two requests that was seen alone sets the master: set then clear gives 0, and clear then set gives 1.
- R5: `bad_combo` is 1 for the cycle after an edge that samples `pulse`, `set_req` and `clr_req` all high, and the master then keeps its value. Both requests together while `pulse` is low do not raise the flag.
- R6: `force_lo_n` low drives `q` to 0, and (with `force_lo_n` high) `force_hi_n` low drives `q` to 1. Either one takes effect on the edge that samples it, whatever the level of `pulse`, and sets the master to the same value.
- R7: With both direct inputs low, the clear wins (`q` = 0, master 0) and `bad_combo` is 1 for that cycle, even at the end of a pulse.
- R8: `q_n` is always the inverse of `q`. Asserting `rst_n` low gives `q` = 0, `q_n` = 1, `bad_combo` = 0 and master 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous system reset, active low |
| pulse | input | 1 | Control pulse; the master listens while it is high |
| set_req | input | 1 | Set request to the master |
| clr_req | input | 1 | Clear request to the master |
| force_lo_n | input | 1 | Direct clear, active low, has priority |
| force_hi_n | input | 1 | Direct set, active low |
| q | output | 1 | Stored value |
| q_n | output | 1 | Inverse of the stored value |
| bad_combo | output | 1 | Disallowed request flag |

## Verification
Every output is one register deep. Any input sampled on a rising edge shows on `q`, `q_n` and `bad_combo` right after that same edge. The end of a pulse also counts as one register: the edge that first sees `pulse` low is the edge that updates `q`. The bench drives each vector on the falling edge and compares the outputs 1 ns after the next rising edge, so each comparison sees exactly one edge's worth of effect. Ones-catching and request ordering are checked across several consecutive vectors, because the master's hidden value shows on `q` only when the pulse ends.

// File: rtl/ms_sr_store.sv
module ms_sr_store (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse,
  input  logic set_req,
  input  logic clr_req,
  input  logic force_lo_n,
  input  logic force_hi_n,
  output logic q,
  output logic q_n,
  output logic bad_combo
);

  logic pulse_d, master, q_r, qn_r, bad_r;
  logic m_nxt, q_nxt;

  wire pulse_end = pulse_d & ~pulse;
  wire dir_clr   = ~force_lo_n;
  wire dir_set   = ~force_hi_n & force_lo_n;
  wire both_req  = pulse & set_req & clr_req;

  always_comb begin
    m_nxt = master;
    if (pulse) begin
      if (set_req & ~clr_req)      m_nxt = 1'b1;
      else if (clr_req & ~set_req) m_nxt = 1'b0;
    end
    if (dir_clr)      m_nxt = 1'b0;
    else if (dir_set) m_nxt = 1'b1;
  end

  always_comb begin
    q_nxt = q_r;
    if (pulse_end)    q_nxt = master;
    if (dir_clr)      q_nxt = 1'b0;
    else if (dir_set) q_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_d <= 1'b0;
      master  <= 1'b0;
      q_r     <= 1'b0;
      qn_r    <= 1'b1;
      bad_r   <= 1'b0;
    end else begin
      pulse_d <= pulse;
      master  <= m_nxt;
      q_r     <= q_nxt;
      qn_r    <= ~q_nxt;
      bad_r   <= both_req | (dir_clr & ~force_hi_n);
    end
  end

  assign q         = q_r;
  assign q_n       = qn_r;
  assign bad_combo = bad_r;

  p_hold_in_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && force_lo_n && force_hi_n) |=> $stable(q));

  p_copy_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_d && !pulse && force_lo_n && force_hi_n) |=> (q == $past(master)));

  p_flag_on_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && set_req && clr_req) |=> bad_combo);

  p_direct_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_lo_n) |=> (!q && !master));

  p_direct_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (force_lo_n && !force_hi_n) |=> (q && master));

  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_lo_n && !force_hi_n) |=> (!q && bad_combo));

  p_complement_r8: assert property (@(posedge clk) disable iff (!rst_n)
    q_n == !q);

endmodule

// File: tb/ms_sr_store_test.sv
module ms_sr_store_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse = 1'b0, set_req = 1'b0, clr_req = 1'b0;
  logic force_lo_n = 1'b1, force_hi_n = 1'b1;
  logic q, q_n, bad_combo;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  ms_sr_store uut (
    .clk(clk), .rst_n(rst_n), .pulse(pulse), .set_req(set_req),
    .clr_req(clr_req), .force_lo_n(force_lo_n), .force_hi_n(force_hi_n),
    .q(q), .q_n(q_n), .bad_combo(bad_combo)
  );

  // {pulse, set_req, clr_req, force_lo_n, force_hi_n, exp_q, exp_flag}
  localparam int NV = 27;
  localparam logic [6:0] VEC [NV] = '{
    7'b0_0_0_11_0_0,  // idle
    7'b1_1_0_11_0_0,  // R1 set seen, q holds
    7'b1_0_0_11_0_0,  // R3 set gone, q still holds
    7'b0_0_0_11_1_0,  // R3 end of pulse, caught 1
    7'b0_0_1_11_1_0,  // R2 clear with pulse low ignored
    7'b1_0_1_11_1_0,  // R1 clear in pulse, q holds
    7'b0_0_0_11_0_0,  // R2 copy 0
    7'b1_1_0_11_0_0,  // R4 set first
    7'b1_0_1_11_0_0,  // R4 then clear
    7'b0_0_0_11_0_0,  // R4 clear wins
    7'b1_1_1_11_0_1,  // R5 both in pulse
    7'b1_0_0_11_0_0,  // R5 flag drops
    7'b0_0_0_11_0_0,  // R5 master kept 0
    7'b0_1_0_11_0_0,  // R2 set with pulse low ignored
    7'b0_1_1_11_0_0,  // R5 both, pulse low: no flag
    7'b0_0_0_10_1_0,  // R6 direct set
    7'b0_0_0_11_1_0,  // R6 holds after release
    7'b1_0_0_11_1_0,  // R6 master was forced 1
    7'b0_0_0_11_1_0,  // R6 copy of forced master
    7'b1_0_0_01_0_0,  // R6 direct clear in pulse
    7'b1_1_0_11_0_0,  // R1 set in pulse
    7'b0_0_0_00_0_1,  // R7 clear wins at pulse end
    7'b1_0_0_11_0_0,  // R7 flag drops
    7'b0_0_0_11_0_0,  // R7 master forced 0
    7'b1_1_0_11_0_0,  // R1 long pulse
    7'b1_1_0_11_0_0,  // R1 still holds
    7'b0_1_0_11_1_0   // R2 copy at end though set still high
  };

  task automatic check(input string req, input logic exp_q, input logic exp_f);
    n_chk++;
    if (q !== exp_q || q_n !== ~exp_q || bad_combo !== exp_f) begin
      n_bad++;
      $display("FAIL %s: q=%b q_n=%b flag=%b, expected q=%b q_n=%b flag=%b",
               req, q, q_n, bad_combo, exp_q, ~exp_q, exp_f);
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R8 reset state", 1'b0, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {pulse, set_req, clr_req, force_lo_n, force_hi_n} = VEC[i][6:2];
      @(posedge clk);
      #1 check($sformatf("vector %0d", i), VEC[i][1], VEC[i][0]);
    end

    // R8: system reset mid-run clears a stored 1
    @(negedge clk);
    {pulse, set_req, clr_req, force_lo_n, force_hi_n} = 5'b00011;
    rst_n = 1'b0;
    #1 check("R8 async reset", 1'b0, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    // R3: one-cycle set blip in a long pulse
    @(negedge clk) {pulse, set_req} = 2'b11;
    @(negedge clk) set_req = 1'b0;
    repeat (3) @(negedge clk);
    @(posedge clk) #1 check("R1 long pulse after blip", 1'b0, 1'b0);
    @(negedge clk) pulse = 1'b0;
    @(posedge clk) #1 check("R3 blip caught", 1'b1, 1'b0);

    // R4: clear then set in one pulse gives 1 (q already 1, so clear first to 0)
    @(negedge clk) {pulse, clr_req} = 2'b11;
    @(negedge clk) pulse = 1'b0;
    @(negedge clk) clr_req = 1'b0;
    @(posedge clk) #1 check("R4 clear pulse", 1'b0, 1'b0);
    @(negedge clk) {pulse, clr_req} = 2'b11;
    @(negedge clk) {set_req, clr_req} = 2'b10;
    @(negedge clk) {pulse, set_req} = 2'b00;
    @(posedge clk) #1 check("R4 set last wins", 1'b1, 1'b0);

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule